// File: doc/BRIEF.md
# Error Transaction-ID Capture Registers

This block watches the retire events of a memory and data-path controller and keeps a record of which transaction first failed in each of three error classes. Every retire event carries a 6-bit transaction ID and three flags: a corrected single-bit error, an uncorrectable double-bit error, and a data-path error. The block decides which class the event belongs to. It then loads the ID into that class's status register, unless the register is already holding an earlier ID or its class is disabled.

Software sees the three status registers through a byte-wide offset-addressed port. Writes take effect at the clock edge, and reads are combinational from the offset. Each register holds a disable bit, a valid bit and the captured ID. Software writes a one to the valid bit to release the register, and it can then capture again.

The registers are sticky. Only the cold (power-on) reset clears them. A warm reset leaves their contents as they are, and while it is asserted the block ignores both retire events and software writes.

Each register slot runs a two-state machine. In `SLOT_OPEN` the slot is empty. In `SLOT_HELD` it holds a captured ID. The transition *capture* goes from `SLOT_OPEN` to `SLOT_HELD` on a matching event while the slot is enabled and no release is written in the same cycle. The transition *release* goes from `SLOT_HELD` to `SLOT_OPEN` on a write-1 to the valid bit. In every other case the slot stays where it is: *hold* in `SLOT_HELD` and *idle* in `SLOT_OPEN`.

Top module: `err_tid_capture`

## Requirements
- R1: After cold reset all three registers read 00h. Any offset other than 80h, 81h and 82h always reads 00h.
- R2: The corrected-error register is at offset 80h, the double-bit register at 81h and the data-path register at 82h. In each register, bit 7 is the disable bit, bit 6 is the valid bit and bits 5:0 are the captured ID.
- R3: A retire event with the double-bit flag set belongs to the double-bit class, whatever the other flags are.
- R4: A retire event with the corrected flag set and the double-bit flag clear belongs to the corrected-error class.
- R5: A retire event belongs to the data-path class only when the data-path flag is set and both other flags are clear.
- R6: A capture takes place at the clock edge where rtr_vld is high. From the next cycle the register reads with valid set and the event's ID in bits 5:0. Flags that arrive with rtr_vld low have no effect.
- R7: While the valid bit is set, later events of the same class leave the stored ID unchanged.
- R8: A write with bit 6 set clears the valid bit and the ID. A write with bit 6 clear leaves them unchanged. Bits 5:0 of the write data are never stored.
- R9: If a release write and a matching event reach the same register in the same cycle, the release wins and the register ends up empty.
- R10: Bit 7 can be both written and read. While it is set, matching events do not change the register.
- R11: While warm_rst_n is low, the register contents are kept, and retire events and writes are ignored.
- R12: A write to an unmapped offset changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, active low; clears the registers |
| warm_rst_n | input | 1 | Warm reset, active low; freezes the registers |
| rtr_vld | input | 1 | Retire event valid |
| rtr_tid | input | 6 | Transaction ID of the retiring transaction |
| rtr_corr | input | 1 | Corrected single-bit error flag |
| rtr_uncorr | input | 1 | Double-bit error flag |
| rtr_data_err | input | 1 | Data-path error flag |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr |

## Verification
The bench targets the flag combinations where the classes overlap. An event with all three flags set must land only in the double-bit register, and a data-path flag that comes with another flag must not reach the data-path register. A wrong priority would fill two registers from one event, or the wrong register.

Further directed cases cover the following, and the faulty behaviour each one exposes:
- A second error while a register is held. A faulty design would overwrite the first ID.
- A release write that coincides with a capture. A faulty design would leave the register valid.
- Writes with bit 6 clear but ID bits set. A faulty design would release the register or corrupt the ID.
- Events while the class is disabled.
- Activity during warm reset. A faulty design would lose or change the sticky contents.

Random traffic, with writes mixed in at the register boundaries, is checked against a reference model.

// File: rtl/etc_pkg.sv
package etc_pkg;

    localparam int NUM_CLASS = 3;

    // Class index also fixes the register offset relative to the base.
    typedef enum logic [1:0] {
        CLS_CORR   = 2'd0,
        CLS_UNCORR = 2'd1,
        CLS_DPATH  = 2'd2
    } err_class_e;

    typedef enum logic {
        SLOT_OPEN = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/etc_classify.sv
module etc_classify
    import etc_pkg::*;
(
    input  logic                 evt_vld,
    input  logic                 flag_corr,
    input  logic                 flag_uncorr,
    input  logic                 flag_dpath,
    output logic [NUM_CLASS-1:0] class_hit
);

    always_comb begin
        class_hit = '0;
        if (evt_vld) begin
            // Double-bit dominates, then corrected, then data-path.
            class_hit[CLS_UNCORR] = flag_uncorr;
            class_hit[CLS_CORR]   = flag_corr && !flag_uncorr;
            class_hit[CLS_DPATH]  = flag_dpath && !flag_corr && !flag_uncorr;
        end
    end

    // R3
    always_comb begin
        class_single_chk: assert ($onehot0(class_hit));
    end

endmodule

// File: rtl/etc_slot.sv
module etc_slot
    import etc_pkg::*;
#(
    parameter int TID_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_req,
    input  logic [TID_W-1:0] cap_tid,
    input  logic             wr_sel,
    input  logic             wr_dis,
    input  logic             wr_clr,
    output logic [TID_W+1:0] word
);

    slot_state_e      state_q, state_d;
    logic [TID_W-1:0] tid_q, tid_d;
    logic             dis_q;
    logic             take_id;

    // State register (sticky: cold reset only)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_OPEN;
            tid_q   <= '0;
            dis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tid_q   <= tid_d;
            if (wr_sel) begin
                dis_q <= wr_dis;
            end
        end
    end

    // Next state: capture / release / hold / idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_OPEN: begin
                if (wr_clr) begin
                    state_d = SLOT_OPEN;
                end else if (cap_req && !dis_q) begin
                    state_d = SLOT_HELD;
                end
            end
            SLOT_HELD: begin
                if (wr_clr) begin
                    state_d = SLOT_OPEN;
                end
            end
            default: state_d = SLOT_OPEN;
        endcase
    end

    always_comb begin
        take_id = (state_q == SLOT_OPEN) && (state_d == SLOT_HELD);
        if (wr_clr) begin
            tid_d = '0;
        end else if (take_id) begin
            tid_d = cap_tid;
        end else begin
            tid_d = tid_q;
        end
    end

    // Outputs
    always_comb begin
        word = {dis_q, (state_q == SLOT_HELD), tid_q};
    end

    // R6
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_OPEN && !dis_q && cap_req && !wr_clr)
        |=> (state_q == SLOT_HELD && tid_q == $past(cap_tid)));

    // R7
    held_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && !wr_clr)
        |=> (state_q == SLOT_HELD && $stable(tid_q)));

    // R8
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (state_q == SLOT_OPEN && tid_q == '0));

    // R10
    disable_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_OPEN && dis_q) |=> (state_q == SLOT_OPEN));

    // R10
    disable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (dis_q == $past(wr_dis)));

endmodule

// File: rtl/etc_regmux.sv
module etc_regmux
    import etc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 'h80
) (
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [1:0]                        wctl,
    input  logic [NUM_CLASS-1:0][DATA_W-1:0]  rd_words,
    output logic [NUM_CLASS-1:0]              wr_sel,
    output logic [NUM_CLASS-1:0]              wr_clr,
    output logic                              wr_dis,
    output logic [DATA_W-1:0]                 rdata
);

    assign wr_dis = wctl[1];

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_dec
        assign wr_sel[g] = wr_en && (addr == ADDR_W'(BASE_ADDR + g));
        assign wr_clr[g] = wr_sel[g] && wctl[0];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CLASS; i++) begin
            if (addr == ADDR_W'(BASE_ADDR + i)) begin
                rdata = rd_words[i];
            end
        end
    end

    // R12
    always_comb begin
        wr_onehot_chk: assert ($onehot0(wr_sel));
    end

endmodule

// File: rtl/err_tid_capture.sv
module err_tid_capture
    import etc_pkg::*;
#(
    parameter int TID_W     = 6,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h80
) (
    input  logic                clk,
    input  logic                cold_rst_n,
    input  logic                warm_rst_n,
    input  logic                rtr_vld,
    input  logic [TID_W-1:0]    rtr_tid,
    input  logic                rtr_corr,
    input  logic                rtr_uncorr,
    input  logic                rtr_data_err,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [TID_W+1:0]    cfg_wdata,
    output logic [TID_W+1:0]    cfg_rdata
);

    localparam int DATA_W = TID_W + 2;

    logic                             evt_live;
    logic                             wr_live;
    logic [NUM_CLASS-1:0]             class_hit;
    logic [NUM_CLASS-1:0]             wr_sel;
    logic [NUM_CLASS-1:0]             wr_clr;
    logic                             wr_dis;
    logic [NUM_CLASS-1:0][DATA_W-1:0] words;
    logic                             unused_wdata_bits;

    // Warm reset freezes the sticky state by blocking every update path.
    assign evt_live          = rtr_vld && warm_rst_n;
    assign wr_live           = cfg_wr && warm_rst_n;
    assign unused_wdata_bits = ^cfg_wdata[TID_W-1:0];

    etc_classify u_classify (
        .evt_vld     (evt_live),
        .flag_corr   (rtr_corr),
        .flag_uncorr (rtr_uncorr),
        .flag_dpath  (rtr_data_err),
        .class_hit   (class_hit)
    );

    etc_regmux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regmux (
        .wr_en    (wr_live),
        .addr     (cfg_addr),
        .wctl     (cfg_wdata[DATA_W-1 -: 2]),
        .rd_words (words),
        .wr_sel   (wr_sel),
        .wr_clr   (wr_clr),
        .wr_dis   (wr_dis),
        .rdata    (cfg_rdata)
    );

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_slot
        etc_slot #(
            .TID_W (TID_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (cold_rst_n),
            .cap_req (class_hit[g]),
            .cap_tid (rtr_tid),
            .wr_sel  (wr_sel[g]),
            .wr_dis  (wr_dis),
            .wr_clr  (wr_clr[g]),
            .word    (words[g])
        );
    end

    // R11
    warm_freeze_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |=> $stable(words));

endmodule

// File: tb/err_tid_capture_tb_top.sv
`timescale 1ns/1ps
module err_tid_capture_tb_top;

    logic       clk = 1'b0;
    logic       cold_rst_n = 1'b0;
    logic       warm_rst_n = 1'b1;
    logic       rtr_vld = 1'b0;
    logic [5:0] rtr_tid = '0;
    logic       rtr_corr = 1'b0;
    logic       rtr_uncorr = 1'b0;
    logic       rtr_data_err = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [3];

    always #2.5 clk = ~clk;

    err_tid_capture dut_i (
        .clk          (clk),
        .cold_rst_n   (cold_rst_n),
        .warm_rst_n   (warm_rst_n),
        .rtr_vld      (rtr_vld),
        .rtr_tid      (rtr_tid),
        .rtr_corr     (rtr_corr),
        .rtr_uncorr   (rtr_uncorr),
        .rtr_data_err (rtr_data_err),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata)
    );

    // Reference: next value of register idx from the requirements.
    function automatic logic [7:0] mdl_next(int idx, logic [7:0] cur);
        logic [7:0] nxt = cur;
        logic       hit;
        logic       sel;
        if (!warm_rst_n) return cur;
        case (idx)
            0:       hit = rtr_vld && rtr_corr && !rtr_uncorr;
            1:       hit = rtr_vld && rtr_uncorr;
            default: hit = rtr_vld && rtr_data_err && !rtr_corr && !rtr_uncorr;
        endcase
        sel = cfg_wr && (cfg_addr == 8'h80 + 8'(idx));
        if (sel) nxt[7] = cfg_wdata[7];
        if (sel && cfg_wdata[6]) begin
            nxt[6:0] = '0;
        end else if (hit && !cur[7] && !cur[6]) begin
            nxt[6]   = 1'b1;
            nxt[5:0] = rtr_tid;
        end
        return nxt;
    endfunction

    task automatic chk(input logic [7:0] addr, input logic [7:0] exp, input string req);
        cfg_addr = addr;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, addr, cfg_rdata, exp);
        end
    endtask

    task automatic chk_model(input string req);
        for (int i = 0; i < 3; i++) chk(8'h80 + 8'(i), mdl[i], req);
    endtask

    // Called after a negedge; drives for one posedge, ends at the next negedge.
    task automatic step(input logic v, input logic [5:0] t, input logic c, input logic u,
                        input logic d, input logic w, input logic [7:0] a, input logic [7:0] wd);
        rtr_vld = v; rtr_tid = t; rtr_corr = c; rtr_uncorr = u; rtr_data_err = d;
        cfg_wr = w; cfg_addr = a; cfg_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < 3; i++) mdl[i] = mdl_next(i, mdl[i]);
        @(negedge clk);
        rtr_vld = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cold_reset();
        cold_rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cold_rst_n = 1'b1;
        for (int i = 0; i < 3; i++) mdl[i] = 8'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cold_reset();
        // R1 reset state and unmapped read
        chk(8'h80, 8'h00, "R1");
        chk(8'h81, 8'h00, "R1");
        chk(8'h82, 8'h00, "R1");
        chk(8'h83, 8'h00, "R1");

        // R6: flags without valid do nothing
        step(1'b0, 6'h2C, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        chk_model("R6");
        chk(8'h81, 8'h00, "R6");

        // R4 R6 R2: corrected capture at 80h
        step(1'b1, 6'h15, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        chk(8'h80, 8'h55, "R4");
        chk(8'h81, 8'h00, "R2");

        // R3: all flags -> double-bit only
        step(1'b1, 6'h2A, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        chk(8'h81, 8'h6A, "R3");
        chk(8'h82, 8'h00, "R3");
        chk(8'h80, 8'h55, "R3");

        // R7: second double-bit error kept out
        step(1'b1, 6'h01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        chk(8'h81, 8'h6A, "R7");

        // R5: data-path flag with corrected flag is not data-path
        step(1'b1, 6'h07, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        chk(8'h82, 8'h00, "R5");
        step(1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        chk(8'h82, 8'h7F, "R5");

        // R8: zero in bit 6 and ID bits have no effect; one in bit 6 clears
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h00);
        chk(8'h81, 8'h6A, "R8");
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h3F);
        chk(8'h81, 8'h6A, "R8");
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h40);
        chk(8'h81, 8'h00, "R8");

        // R9: release and capture in the same cycle
        step(1'b1, 6'h11, 1'b0, 1'b1, 1'b0, 1'b1, 8'h81, 8'h40);
        chk(8'h81, 8'h00, "R9");

        // R10: disable bit
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h80);
        chk(8'h81, 8'h80, "R10");
        step(1'b1, 6'h22, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        chk(8'h81, 8'h80, "R10");
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h00);
        step(1'b1, 6'h22, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        chk(8'h81, 8'h62, "R10");

        // R12: unmapped writes
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h83, 8'hC0);
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7F, 8'hC0);
        chk(8'h80, 8'h55, "R12");
        chk(8'h81, 8'h62, "R12");
        chk(8'h82, 8'h7F, "R12");
        chk(8'h83, 8'h00, "R12");

        // R11: warm reset freezes contents
        warm_rst_n = 1'b0;
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'hC0);
        chk(8'h80, 8'h55, "R11");
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h82, 8'h40);
        chk(8'h82, 8'h7F, "R11");
        warm_rst_n = 1'b1;
        step(1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h82, 8'h40);
        warm_rst_n = 1'b0;
        step(1'b1, 6'h09, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        chk(8'h82, 8'h00, "R11");
        warm_rst_n = 1'b1;
        chk_model("R11");

        // R1: cold reset clears sticky state
        cold_reset();
        chk_model("R1");

        // Random traffic against the model (R3 to R12)
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            warm_rst_n = ($urandom % 20) != 0;
            step(($urandom % 4) != 0, 6'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom % 4) == 0, 8'h7F + 8'($urandom % 6),
                 8'($urandom));
            chk_model("R7_R8_R10_rand");
        end
        warm_rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule